// File: doc/BRIEF.md
# SHA3-256 Streaming Sponge

This block computes SHA3-256 digests over a message delivered as a stream of 64-bit words. Words are handed over with a valid/ready pair: `msg_load` offers a word and `msg_ack` accepts it. Seventeen accepted words form one 1088-bit rate block. Each block is XORed into the low seventeen lanes of a 1600-bit state, and the 512-bit capacity is left as it was. An iterative Keccak-f[1600] engine then applies one round per clock, twenty-four rounds in all.

The host pads the message itself. It appends the 0x06 domain byte and sets bit 7 of the final byte of the last block. It also raises `msg_last` together with the seventeenth word of that block. Once the last permutation has run, four digest words stream out on `hash_word` under a `hash_valid`/`hash_ready` pair. After the fourth word the state is cleared and the block accepts a new message.

Back-pressure works as follows. On the input side, `msg_ack` stays low whenever the block is busy permuting or emitting a digest, and words offered during that time are not taken. On the output side, while `hash_ready` is low the current `hash_word` and `hash_valid` are held unchanged.

Top module: `sha3_sponge_stream`

## Requirements
- R1: After reset the state is all zeros, `msg_ack` is 1 and `hash_valid` is 0.
- R2: A word is taken on a clock edge where `msg_load` and `msg_ack` are both 1. Message byte i of a word occupies bits 8i+7..8i, and the k-th word of a block (k = 0..16) is XORed into lane k, which is state bits 64k+63..64k.
- R3: The block is XORed into the state on the edge that takes the seventeenth word. State bits 1599..1088 (the capacity) are unchanged by that XOR, and the permutation starts on the next cycle.
- R4: After a non-final block, `msg_ack` is 0 for exactly 24 cycles (one Keccak round per cycle). Words offered during that window are ignored.
- R5: `msg_last` is sampled only with the seventeenth word of a block. When it is 1, the digest follows the permutation. When it is 0, the block returns to accepting words and keeps the state.
- R6: Exactly four digest words are produced, lanes 0, 1, 2, 3 in that order. Byte i of the digest is in bits 8(i mod 8)+7..8(i mod 8) of word i/8. The digest equals SHA3-256 of the unpadded message.
- R7: While `hash_valid` is 1 and `hash_ready` is 0, `hash_valid` stays 1 and `hash_word` does not change.
- R8: On the cycle after the fourth digest word is taken, `hash_valid` is 0, `msg_ack` is 1 and the state is zero, so the next message hashes independently.
- R9: `msg_ack` is 0 whenever `hash_valid` is 1, so input offered during the digest output is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_load | input | 1 | A message word is offered |
| msg_ack | output | 1 | The block accepts the offered word this cycle |
| msg_word | input | 64 | Message word, little-endian bytes |
| msg_last | input | 1 | Marks the seventeenth word of the final block |
| hash_valid | output | 1 | A digest word is present on `hash_word` |
| hash_ready | input | 1 | The consumer takes the digest word this cycle |
| hash_word | output | 64 | Digest word, lane order 0 to 3 |

## Verification
The bench targets the following corner cases:

- **Message lengths.** It hashes the empty message, a three-byte message and a two-block message of 200 bytes. A lane or byte ordering error, or a capacity that the absorb step disturbs, changes every digest word.
- **Input during busy periods.** Garbage words with `msg_last` set are held on the input throughout each permutation and digest phase. A design that lets them through corrupts the next block or ends the message early, and the length of the `msg_ack` low window is measured as well.
- **Output stalls.** The consumer stalls on alternate cycles during one digest. A design that advances on a stall would skip or repeat words.
- **Back-to-back messages.** A repeated empty message after the long one exposes a state that was not cleared.

// File: rtl/sha3_sponge_pkg.sv
package sha3_sponge_pkg;

  localparam int LANE_W       = 64;
  localparam int NUM_LANES    = 25;
  localparam int STATE_W      = NUM_LANES * LANE_W;
  localparam int RATE_LANES   = 17;
  localparam int RATE_W       = RATE_LANES * LANE_W;
  localparam int DIGEST_LANES = 4;
  localparam int DIGEST_W     = DIGEST_LANES * LANE_W;
  localparam int NUM_ROUNDS   = 24;
  localparam int RND_W        = $clog2(NUM_ROUNDS);

  typedef enum logic [1:0] {
    PH_ABSORB  = 2'd0,
    PH_PERMUTE = 2'd1,
    PH_SQUEEZE = 2'd2
  } sponge_phase_e;

  // Output bit of the degree-8 LFSR used for round constants, step t.
  function automatic logic lfsr_bit(input int t);
    logic [7:0] r;
    logic       fb;
    int         steps;
    r     = 8'h01;
    steps = t % 255;
    for (int k = 1; k < 255; k++) begin
      if (k <= steps) begin
        fb   = r[7];
        r    = {r[6:0], 1'b0};
        r[0] = r[0] ^ fb;
        r[4] = r[4] ^ fb;
        r[5] = r[5] ^ fb;
        r[6] = r[6] ^ fb;
      end
    end
    return r[0];
  endfunction

  function automatic logic [LANE_W-1:0] round_const(input int rnd);
    logic [LANE_W-1:0] v;
    v = '0;
    for (int j = 0; j < 7; j++) begin
      v[(1 << j) - 1] = lfsr_bit(j + 7 * rnd);
    end
    return v;
  endfunction

  // Rotation amount for lane (x,y), derived by walking the lane cycle.
  function automatic int rot_amount(input int x, input int y);
    int cx, cy, nx, ny, res;
    cx  = 1;
    cy  = 0;
    res = 0;
    for (int t = 0; t < 24; t++) begin
      if (cx == x && cy == y) res = ((t + 1) * (t + 2) / 2) % LANE_W;
      nx = cy;
      ny = (2 * cx + 3 * cy) % 5;
      cx = nx;
      cy = ny;
    end
    return res;
  endfunction

endpackage

// File: rtl/sponge_word_collector.sv
module sponge_word_collector
  import sha3_sponge_pkg::*;
#(
  parameter int WORD_W = LANE_W,
  parameter int WORDS  = RATE_LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [WORD_W-1:0]       word,
  output logic [WORDS*WORD_W-1:0] block,
  output logic                    blk_done
);

  localparam int SIPO_W = (WORDS - 1) * WORD_W;
  localparam int CNT_W  = $clog2(WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

  logic [SIPO_W-1:0] sipo_q;
  logic [CNT_W-1:0]  fill_q;

  assign blk_done = take && (fill_q == LAST_IDX);
  assign block    = {word, sipo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sipo_q <= '0;
      fill_q <= '0;
    end else if (take) begin
      sipo_q <= {word, sipo_q[SIPO_W-1:WORD_W]};
      fill_q <= blk_done ? '0 : fill_q + 1'b1;
    end
  end

  AST_FILL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (fill_q == '0)); // R3

endmodule

// File: rtl/keccak_round.sv
module keccak_round
  import sha3_sponge_pkg::*;
#(
  parameter int IDX_W = RND_W
) (
  input  logic [STATE_W-1:0] st_in,
  input  logic [IDX_W-1:0]   rnd_idx,
  output logic [STATE_W-1:0] st_out
);

  localparam int TAB_N = 1 << IDX_W;

  logic [LANE_W-1:0] a_l   [NUM_LANES];
  logic [LANE_W-1:0] col_l [5];
  logic [LANE_W-1:0] mix_l [5];
  logic [LANE_W-1:0] prm_l [NUM_LANES];
  logic [LANE_W-1:0] chi_l [NUM_LANES];
  logic [LANE_W-1:0] rc_tab [TAB_N];
  logic [LANE_W-1:0] rc_sel;

  genvar gi, gx, gy;

  generate
    for (gi = 0; gi < TAB_N; gi++) begin : g_rc
      if (gi < NUM_ROUNDS) begin : g_used
        localparam logic [LANE_W-1:0] RCV = round_const(gi);
        assign rc_tab[gi] = RCV;
      end else begin : g_pad
        assign rc_tab[gi] = '0;
      end
    end

    for (gi = 0; gi < NUM_LANES; gi++) begin : g_unpack
      assign a_l[gi] = st_in[gi*LANE_W +: LANE_W];
    end

    // Column parity and the per-column mixing term.
    for (gx = 0; gx < 5; gx++) begin : g_col
      localparam int XM = (gx + 4) % 5;
      localparam int XP = (gx + 1) % 5;
      assign col_l[gx] = a_l[gx] ^ a_l[gx+5] ^ a_l[gx+10] ^ a_l[gx+15] ^ a_l[gx+20];
      assign mix_l[gx] = col_l[XM] ^ {col_l[XP][LANE_W-2:0], col_l[XP][LANE_W-1]};
    end

    // Parity mixing, lane rotation and lane relocation.
    for (gx = 0; gx < 5; gx++) begin : g_px
      for (gy = 0; gy < 5; gy++) begin : g_py
        localparam int SRC = gx + 5 * gy;
        localparam int DST = gy + 5 * ((2 * gx + 3 * gy) % 5);
        localparam int ROT = rot_amount(gx, gy);
        logic [LANE_W-1:0] t_l;
        assign t_l = a_l[SRC] ^ mix_l[gx];
        if (ROT == 0) begin : g_norot
          assign prm_l[DST] = t_l;
        end else begin : g_rot
          assign prm_l[DST] = {t_l[LANE_W-1-ROT:0], t_l[LANE_W-1:LANE_W-ROT]};
        end
      end
    end

    // Row-wise nonlinear step.
    for (gx = 0; gx < 5; gx++) begin : g_cx
      for (gy = 0; gy < 5; gy++) begin : g_cy
        localparam int I0 = gx + 5 * gy;
        localparam int I1 = (gx + 1) % 5 + 5 * gy;
        localparam int I2 = (gx + 2) % 5 + 5 * gy;
        assign chi_l[I0] = prm_l[I0] ^ (~prm_l[I1] & prm_l[I2]);
      end
    end
  endgenerate

  assign rc_sel = rc_tab[rnd_idx];

  generate
    for (gi = 0; gi < NUM_LANES; gi++) begin : g_pack
      if (gi == 0) begin : g_iota
        assign st_out[gi*LANE_W +: LANE_W] = chi_l[gi] ^ rc_sel;
      end else begin : g_copy
        assign st_out[gi*LANE_W +: LANE_W] = chi_l[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/sponge_digest_shifter.sv
module sponge_digest_shifter
  import sha3_sponge_pkg::*;
#(
  parameter int WORD_W = LANE_W,
  parameter int WORDS  = DIGEST_LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORDS*WORD_W-1:0] load_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_word,
  output logic                    drained
);

  localparam int PISO_W = WORDS * WORD_W;
  localparam int CNT_W  = $clog2(WORDS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [PISO_W-1:0] piso_q;
  logic [CNT_W-1:0]  left_q;
  logic              take;

  assign out_valid = (left_q != '0);
  assign out_word  = piso_q[WORD_W-1:0];
  assign take      = out_valid && out_ready;
  assign drained   = take && (left_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      piso_q <= '0;
      left_q <= '0;
    end else if (load) begin
      piso_q <= load_data;
      left_q <= FULL;
    end else if (take) begin
      piso_q <= {{WORD_W{1'b0}}, piso_q[PISO_W-1:WORD_W]};
      left_q <= left_q - 1'b1;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_word))); // R7

  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid); // R6

endmodule

// File: rtl/sha3_sponge_stream.sv
module sha3_sponge_stream
  import sha3_sponge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_load,
  output logic              msg_ack,
  input  logic [LANE_W-1:0] msg_word,
  input  logic              msg_last,
  output logic              hash_valid,
  input  logic              hash_ready,
  output logic [LANE_W-1:0] hash_word
);

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

  sponge_phase_e      phase_q;
  logic [RND_W-1:0]   rnd_q;
  logic               last_q;
  logic [STATE_W-1:0] state_q;

  logic               take_in;
  logic [RATE_W-1:0]  rate_blk;
  logic               blk_done;
  logic [STATE_W-1:0] round_out;
  logic               perm_end;
  logic               dig_load;
  logic               drained;

  assign msg_ack  = (phase_q == PH_ABSORB);
  assign take_in  = msg_load && msg_ack;
  assign perm_end = (phase_q == PH_PERMUTE) && (rnd_q == LAST_RND);
  assign dig_load = perm_end && last_q;

  sponge_word_collector #(
    .WORD_W (LANE_W),
    .WORDS  (RATE_LANES)
  ) collector_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_in),
    .word     (msg_word),
    .block    (rate_blk),
    .blk_done (blk_done)
  );

  keccak_round #(
    .IDX_W (RND_W)
  ) round_i (
    .st_in   (state_q),
    .rnd_idx (rnd_q),
    .st_out  (round_out)
  );

  sponge_digest_shifter #(
    .WORD_W (LANE_W),
    .WORDS  (DIGEST_LANES)
  ) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (dig_load),
    .load_data (round_out[DIGEST_W-1:0]),
    .out_valid (hash_valid),
    .out_ready (hash_ready),
    .out_word  (hash_word),
    .drained   (drained)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_ABSORB;
      rnd_q   <= '0;
      last_q  <= 1'b0;
      state_q <= '0;
    end else begin
      case (phase_q)
        PH_ABSORB: begin
          if (blk_done) begin
            state_q[RATE_W-1:0] <= state_q[RATE_W-1:0] ^ rate_blk;
            last_q  <= msg_last;
            rnd_q   <= '0;
            phase_q <= PH_PERMUTE;
          end
        end
        PH_PERMUTE: begin
          state_q <= round_out;
          if (perm_end) begin
            rnd_q   <= '0;
            phase_q <= last_q ? PH_SQUEEZE : PH_ABSORB;
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end
        PH_SQUEEZE: begin
          if (drained) begin
            state_q <= '0;
            last_q  <= 1'b0;
            phase_q <= PH_ABSORB;
          end
        end
        default: phase_q <= PH_ABSORB;
      endcase
    end
  end

  AST_CAPACITY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (state_q[STATE_W-1:RATE_W] == $past(state_q[STATE_W-1:RATE_W]))); // R3

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !msg_ack); // R4

  AST_DIGEST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dig_load |=> hash_valid); // R5

  AST_RESUME_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_end && !last_q) |=> (msg_ack && !hash_valid)); // R5

  AST_CLEAR_AFTER_DIGEST: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> ((state_q == '0) && msg_ack && !hash_valid)); // R8

  AST_NO_ACK_IN_SQUEEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hash_valid |-> !msg_ack); // R9

endmodule

// File: tb/sha3_sponge_stream_tb.sv
module sha3_sponge_stream_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_load = 1'b0;
  logic        msg_ack;
  logic [63:0] msg_word = '0;
  logic        msg_last = 1'b0;
  logic        hash_valid;
  logic        hash_ready = 1'b1;
  logic [63:0] hash_word;

  int n_checks = 0;
  int n_fails  = 0;

  logic [63:0] exp_q[$];
  logic [63:0] blk [17];

  bit          stall_mode = 1'b0;
  bit          tog = 1'b0;
  bit          held_pending = 1'b0;
  logic [63:0] held_word = '0;
  bit          after_pending = 1'b0;
  int          words_seen = 0;
  string       cur_tag = "R6";

  always #2 clk = ~clk;

  sha3_sponge_stream dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_load   (msg_load),
    .msg_ack    (msg_ack),
    .msg_word   (msg_word),
    .msg_last   (msg_last),
    .hash_valid (hash_valid),
    .hash_ready (hash_ready),
    .hash_word  (hash_word)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dig_word(input logic [255:0] d, input int j);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = d[255 - 8*(8*j + b) -: 8];
    return w;
  endfunction

  task automatic expect_digest(input logic [255:0] d);
    for (int j = 0; j < 4; j++) exp_q.push_back(dig_word(d, j));
  endtask

  task automatic clear_blk();
    for (int k = 0; k < 17; k++) blk[k] = '0;
  endtask

  // Driver: offers one block, then holds garbage until the next acceptance window.
  task automatic send_block(input bit is_last);
    int gap;
    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      msg_load = 1'b1;
      msg_word = blk[k];
      msg_last = (k == 16) && is_last;
      while (!msg_ack) @(negedge clk);
    end
    @(negedge clk);
    msg_load = 1'b1;
    msg_word = 64'hDEAD_BEEF_0BAD_F00D;
    msg_last = 1'b1;
    gap = 0;
    while (!msg_ack) begin
      gap++;
      @(negedge clk);
    end
    msg_load = 1'b0;
    msg_last = 1'b0;
    if (!is_last) check(gap == 24, "R4 ack low window", 64'(gap), 64'd24);
  endtask

  // Monitor: pops the scoreboard as digest words are taken.
  always @(negedge clk) begin
    if (rst_n) begin
      if (after_pending) begin
        check(!hash_valid && msg_ack, "R8 idle after digest", {62'd0, hash_valid, msg_ack}, 64'd1);
        after_pending = 1'b0;
      end
      if (held_pending) begin
        check(hash_valid && hash_word == held_word, "R7 stalled word held", hash_word, held_word);
        held_pending = 1'b0;
      end
      hash_ready = stall_mode ? tog : 1'b1;
      tog = ~tog;
      if (hash_valid) begin
        check(!msg_ack, "R9 no ack during digest", {63'd0, msg_ack}, 64'd0);
        if (hash_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected digest word", hash_word, 64'd0);
          end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check(hash_word == e, {cur_tag, " R6 digest word"}, hash_word, e);
          end
          words_seen++;
          if (words_seen % 4 == 0) after_pending = 1'b1;
        end else begin
          held_pending = 1'b1;
          held_word = hash_word;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(msg_ack == 1'b1, "R1 ack after reset", {63'd0, msg_ack}, 64'd1);
    check(hash_valid == 1'b0, "R1 no digest after reset", {63'd0, hash_valid}, 64'd0);

    // Empty message, padding only.
    cur_tag = "R5";
    clear_blk();
    blk[0]  = 64'h0000_0000_0000_0006;
    blk[16] = 64'h8000_0000_0000_0000;
    expect_digest(256'ha7ffc6f8bf1ed76651c14756a061d662f580ff4de43b49fa82d80a4b80f8434a);
    send_block(1'b1);

    // "abc" with a stalling consumer.
    while (exp_q.size() != 0) @(negedge clk);
    stall_mode = 1'b1;
    cur_tag = "R2";
    clear_blk();
    blk[0]  = 64'h0000_0000_0663_6261;
    blk[16] = 64'h8000_0000_0000_0000;
    expect_digest(256'h3a985da74fe225b2045c172d6bd390bd855f086e3e9d525b46bfe24511431532);
    send_block(1'b1);

    // 200 bytes of 0xA3: two blocks.
    while (exp_q.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    cur_tag = "R3";
    for (int k = 0; k < 17; k++) blk[k] = {8{8'hA3}};
    expect_digest(256'h79f38adec5c20307a98ef76e8324afbfd46cfd81b22e3973c65fa1bd9de31787);
    send_block(1'b0);
    clear_blk();
    for (int k = 0; k < 8; k++) blk[k] = {8{8'hA3}};
    blk[8]  = 64'h0000_0000_0000_0006;
    blk[16] = 64'h8000_0000_0000_0000;
    send_block(1'b1);

    // Empty message again: state must start from zero.
    while (exp_q.size() != 0) @(negedge clk);
    cur_tag = "R8";
    clear_blk();
    blk[0]  = 64'h0000_0000_0000_0006;
    blk[16] = 64'h8000_0000_0000_0000;
    expect_digest(256'ha7ffc6f8bf1ed76651c14756a061d662f580ff4de43b49fa82d80a4b80f8434a);
    send_block(1'b1);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(words_seen == 16, "R6 digest word count", 64'(words_seen), 64'd16);
    check(!hash_valid && msg_ack, "R8 final idle", {62'd0, hash_valid, msg_ack}, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule